// File: doc/BRIEF.md
# Extended Mode Register Write Decoder

This block sits on the device side of an SDRAM command bus. On every rising clock edge it samples the chip-select, row-strobe, column-strobe and write-enable pins, the two bank-select lines and the twelve address lines. It picks out writes to the extended mode register. The register holds two settings: a partial-array self-refresh area and an output drive strength. Both are presented as encoded outputs that the refresh control and the I/O drivers use.

A write is accepted only when all of these hold:
- every bank is precharged;
- the clock enable is high;
- all address bits outside the two fields are zero;
- the refresh code is one of the defined ones.

A write that breaks any of these rules leaves the register unchanged and produces a one-cycle error pulse. A successful write opens a two-cycle completion window. During that window busy is high, and any command sent in that window is a violation. The register can be rewritten any number of times.

Top module: `xmr_decoder`

## Requirements
- R1: An extended mode register write is an edge at which cs_n, ras_n, cas_n and we_n are all low and bank_sel equals 2'b10. When it is accepted, addr[2:0] is stored into area_code and addr[6:5] is stored into drive_code, both visible right after that edge.
- R2: After reset, drive_code is 2'b01 (half strength), area_code is 3'b000 (full array), and busy and err are low.
- R3: drive_code encodes the strength as follows: 00 full, 01 one half, 10 one quarter, 11 one eighth. All four codes are stored.
- R4: After an accepted write, busy is high for exactly the two cycles that follow the accepting edge. It is low from the third cycle on.
- R5: While busy is high, a sampled active command is a violation. An active command means cs_n is low and ras_n, cas_n and we_n are not all high. A violation raises err, and a write sent during busy is not stored.
- R6: A write while banks_idle is low is not stored and raises err.
- R7: A write while cke is low is not stored and raises err.
- R8: A write with any of addr[11:7] or addr[4:3] nonzero is not stored and raises err.
- R9: area_code accepts 000 (full), 001 (half) and 010 (quarter). A write carrying 011 through 111 is not stored and raises err.
- R10: err goes high in the cycle after the edge that sampled a rejected command, and only then. A NOP, or any other command sampled outside busy, neither changes the register nor raises err.
- R11: Any number of successive writes is accepted, each under the same conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_sel | input | 2 | Bank select lines |
| addr | input | 12 | Address bus |
| banks_idle | input | 1 | High when all banks are precharged |
| area_code | output | 3 | Stored self-refresh area code |
| drive_code | output | 2 | Stored drive-strength code |
| busy | output | 1 | Write completion window |
| err | output | 1 | One-cycle pulse for a rejected command |

## Verification
The assertions assume the inputs are fully known on every sampling edge after reset. They also assume that banks_idle and cke are plain levels with no timing relation to the command pins, so any pairing of these inputs is legal stimulus. The stimulus drives every input at the falling edge, so every value is stable at the next rising edge. It draws whole commands from a fixed-seed generator, weighted toward legal writes so that busy windows and back-to-back violations happen often. Directed sequences cover each rejection rule, each defined code and the reset values.

// File: rtl/xmr_decoder.sv
module xmr_decoder #(
  parameter int AW          = 12,
  parameter int BUSY_CYCLES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke,
  input  logic          cs_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic [1:0]    bank_sel,
  input  logic [AW-1:0] addr,
  input  logic          banks_idle,
  output logic [2:0]    area_code,
  output logic [1:0]    drive_code,
  output logic          busy,
  output logic          err
);
  localparam int          CW        = $clog2(BUSY_CYCLES + 1);
  localparam logic [AW-1:0] USED    = AW'(7'h67);
  localparam logic [1:0]  DRV_RESET = 2'b01;
  localparam logic [2:0]  AREA_MAX  = 3'b010;

  logic [CW-1:0] busy_cnt;
  logic          active_cmd, ext_wr, fields_ok, accept, reject;

  assign active_cmd = !cs_n && !(ras_n && cas_n && we_n);
  assign ext_wr     = !cs_n && !ras_n && !cas_n && !we_n && bank_sel == 2'b10;
  assign fields_ok  = ((addr & ~USED) == '0) && (addr[2:0] <= AREA_MAX);
  assign accept     = ext_wr && !busy && banks_idle && cke && fields_ok;
  assign reject     = (busy && active_cmd) || (ext_wr && !accept);
  assign busy       = busy_cnt != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      area_code  <= '0;
      drive_code <= DRV_RESET;
      busy_cnt   <= '0;
      err        <= 1'b0;
    end else begin
      err <= reject;
      if (accept) begin
        area_code  <= addr[2:0];
        drive_code <= addr[6:5];
        busy_cnt   <= CW'(BUSY_CYCLES);
      end else if (busy) begin
        busy_cnt <= busy_cnt - 1'b1;
      end
    end
  end

  p_busy_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  p_busy_min_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);
  p_hold_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(area_code) && $stable(drive_code)));
  p_err_keeps_reg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(area_code) && $stable(drive_code)));
  p_area_defined_r9: assert property (@(posedge clk) disable iff (!rst_n)
    area_code <= AREA_MAX);
  p_no_err_without_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !err);
endmodule

// File: tb/xmr_decoder_bench.sv
module xmr_decoder_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] bank_sel = '0;
  logic [11:0] addr = '0;
  logic banks_idle = 1'b1;
  logic [2:0] area_code;
  logic [1:0] drive_code;
  logic busy, err;

  int checks = 0, errors = 0;
  logic [2:0] m_area;
  logic [1:0] m_drv;
  int m_cnt;
  logic m_err;
  bit done = 0;

  always #4 clk = ~clk;

  xmr_decoder u_xmr_decoder (.clk, .rst_n, .cke, .cs_n, .ras_n, .cas_n, .we_n,
    .bank_sel, .addr, .banks_idle, .area_code, .drive_code, .busy, .err);

  function automatic bit f_ext(input logic c, r, a, w, input logic [1:0] b);
    return !c && !r && !a && !w && b == 2'b10;
  endfunction
  function automatic bit f_active(input logic c, r, a, w);
    return !c && !(r && a && w);
  endfunction
  function automatic bit f_fields_ok(input logic [11:0] ad);
    return ((ad & 12'hF98) == 12'h000) && ad[2:0] <= 3'd2;
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic c, r, a, w, input logic [1:0] b,
                      input logic [11:0] ad, input logic idle, k, input string req);
    bit acc, busy_now;
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = a; we_n = w; bank_sel = b; addr = ad;
    banks_idle = idle; cke = k;
    @(posedge clk);
    busy_now = m_cnt != 0;
    acc = f_ext(c, r, a, w, b) && !busy_now && idle && k && f_fields_ok(ad);
    m_err = (busy_now && f_active(c, r, a, w)) || (f_ext(c, r, a, w, b) && !acc);
    if (acc) begin
      m_area = ad[2:0]; m_drv = ad[6:5]; m_cnt = 2;
    end else if (busy_now) m_cnt--;
    #1;
    check({req, " area"}, area_code, m_area);
    check({req, " drive"}, drive_code, m_drv);
    check({req, " busy R4"}, busy, m_cnt != 0);
    check({req, " err R10"}, err, m_err);
  endtask

  task automatic wr(input logic [11:0] ad, input logic idle, k, input string req);
    step(0, 0, 0, 0, 2'b10, ad, idle, k, req);
  endtask
  task automatic nop(input string req);
    step(1, 1, 1, 1, 2'b00, 12'h000, 1, 1, req);
  endtask
  function automatic logic [11:0] fa(input logic [1:0] d, input logic [2:0] ar);
    return {5'b0, d, 2'b0, ar};
  endfunction

  initial begin
    m_area = 3'b000; m_drv = 2'b01; m_cnt = 0; m_err = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R2 area", area_code, 3'b000);
    check("R2 drive", drive_code, 2'b01);
    check("R2 busy", busy, 0);
    check("R2 err", err, 0);
    @(negedge clk) rst_n = 1'b1;
    nop("R10 nop");
    for (int d = 0; d < 4; d++) begin
      wr(fa(d[1:0], 3'(d % 3)), 1, 1, "R1 R3 R11 write");
      nop("R4 window1"); nop("R4 window2"); nop("R4 after");
    end
    wr(fa(2'b10, 3'b001), 1, 1, "R1 write");
    wr(fa(2'b00, 3'b000), 1, 1, "R5 write in busy");
    step(0, 1, 0, 1, 2'b00, 12'h000, 1, 1, "R5 read in busy");
    nop("R5 after");
    wr(fa(2'b11, 3'b010), 0, 1, "R6 not idle");
    wr(fa(2'b11, 3'b010), 1, 0, "R7 cke low");
    wr(fa(2'b00, 3'b000) | 12'h800, 1, 1, "R8 bit11");
    wr(fa(2'b00, 3'b000) | 12'h008, 1, 1, "R8 bit3");
    wr(fa(2'b00, 3'b000) | 12'h080, 1, 1, "R8 bit7");
    for (int ar = 3; ar < 8; ar++) wr(fa(2'b11, 3'(ar)), 1, 1, "R9 reserved");
    step(0, 0, 0, 0, 2'b00, fa(2'b11, 3'b010), 1, 1, "R10 other bank");
    step(0, 1, 0, 1, 2'b00, 12'h000, 1, 1, "R10 read idle");
    for (int i = 0; i < 400; i++) begin
      int kind = $urandom_range(0, 9);
      logic idle = $urandom_range(0, 7) != 0;
      logic k = $urandom_range(0, 7) != 0;
      if (kind < 3) nop("R10 rand nop");
      else if (kind < 7) wr(fa(2'($urandom), 3'($urandom_range(0, 2))), idle, k, "R1 rand write");
      else if (kind == 7) wr(12'($urandom), idle, k, "R8 R9 rand write");
      else step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                12'($urandom), idle, k, "R5 rand cmd");
    end
    done = 1;
  end

  initial begin
    void'($urandom(32'd20240611));
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule